// File: doc/BRIEF.md
# Sequenced Context Slot Scheduler

This block decides which of up to seven virtual processor contexts owns the shared execution slot, and which 64 KB memory bank is mapped for it. The surrounding engine pulses `blk_end` once at the end of every process block. The scheduler counts these pulses for the running context and hands the slot to the next context once a fixed budget of blocks has been used. The running context can also give up the slot early with `yield_req`.

The next context is taken from a programmable sequence table that holds up to 256 entries. A context that appears several times in the table runs more often. A null entry (value 0) does not change the context; it gives the running context one more full budget.

Each context has a one-bit wait flag. A context whose flag is set is reported as halted. A halted context keeps the slot for only one block. It stays halted until its flag is cleared. Context 1 acts as supervisor and may set or clear the flag of any context. Every other context may touch only its own flag.

Top module: `ctx_slot_sched`

## Requirements
- R1: After synchronous reset, `ctx_id` equals table entry 0, which is 1. The table holds (i mod NUM_CTX)+1 at index i, the wrap index is NUM_CTX-1, `bank_sel` is 1, every wait flag is clear and `halted` is 0.
- R2: Without yield or halt, a context keeps the slot for exactly BUDGET (75) `blk_end` pulses. The switch takes effect in the cycle after the 75th pulse. `ctx_id` never changes in a cycle after a cycle without `blk_end`.
- R3: On every switch the table pointer advances by one. After the index held in the wrap register, it returns to 0. The new context is the entry at the new pointer.
- R4: An entry of 0 leaves `ctx_id` and `bank_sel` unchanged. The pointer still advances, and the running context gets a fresh budget of BUDGET blocks.
- R5: `bank_sel` equals the number of the running context. It changes only together with a context switch.
- R6: A `yield_req` pulse sets the block count to its limit, so the switch happens at the next `blk_end`. A yield in the same cycle as `blk_end` switches at that block end.
- R7: `halted` is 1 exactly when the running context's wait flag is 1. A `blk_end` while halted always switches.
- R8: A flag write (`sem_we`, target `sem_target`, value `sem_wait`, 1 = waiting, 0 = signalled) is accepted only when the target is the running context, or when context 1 is running and the target is 1 to NUM_CTX. A write to target 0 or to any other context is ignored.
- R9: `seq_we` writes `seq_ctx` into table index `seq_addr`. `seq_last_we` loads the wrap index. A switch in the same cycle uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_end | input | 1 | Pulse at the end of each process block |
| yield_req | input | 1 | Running context gives up its slot |
| sem_we | input | 1 | Wait flag write strobe from the running context |
| sem_target | input | 3 | Context whose flag is written |
| sem_wait | input | 1 | Flag value: 1 waiting, 0 signalled |
| seq_we | input | 1 | Sequence table write strobe |
| seq_addr | input | PTR_W (8) | Sequence table index |
| seq_ctx | input | 3 | Context number to store, 0 for null |
| seq_last_we | input | 1 | Wrap index write strobe |
| seq_last | input | PTR_W (8) | Last table index before wrap |
| ctx_id | output | 3 | Running context |
| bank_sel | output | BANK_W (3) | Memory bank of the running context |
| halted | output | 1 | Running context is waiting |

## Verification
A wrong block count or pointer shows on `ctx_id` and `bank_sel` at the next switch. That is at most 75 blocks later, or a single block later when a yield or a halt forces the switch. A flag that was wrongly set or cleared stays hidden until its context next gets the slot. At that point `halted` differs in the first cycle, and the context leaves one block early or stays a full budget. For this reason the bench compares all three outputs against its model on every cycle, through fixed scenarios and a long random run.

// File: rtl/ctxsch_pkg.sv
package ctxsch_pkg;

    localparam int CTX_W   = 3;
    localparam int MAX_CTX = 7;

    typedef logic [CTX_W-1:0] ctx_id_t;

    typedef enum logic [1:0] {
        SW_NONE   = 2'd0,
        SW_BUDGET = 2'd1,
        SW_YIELD  = 2'd2,
        SW_HALT   = 2'd3
    } sw_cause_t;

    // Default table contents: contexts 1..n repeated
    function automatic ctx_id_t default_entry(input int idx, input int n);
        return ctx_id_t'((idx % n) + 1);
    endfunction

    // Flag write permission
    function automatic logic flag_write_ok(input ctx_id_t writer, input ctx_id_t target, input int n);
        logic in_range;
        in_range = (target != '0) && (int'(target) <= n);
        return in_range && ((target == writer) || (writer == ctx_id_t'(1)));
    endfunction

endpackage

// File: rtl/ctxsch_seq_table.sv
module ctxsch_seq_table
    import ctxsch_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int NUM_CTX = 7,
    parameter int PTR_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  ctx_id_t          wdata,
    input  logic [PTR_W-1:0] raddr,
    output ctx_id_t          rdata
);

    ctx_id_t entries [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                entries[i] <= default_entry(i, NUM_CTX);
            end
        end else if (we) begin
            entries[waddr] <= wdata;
        end
    end

    assign rdata = entries[raddr];

endmodule

// File: rtl/ctxsch_sem_bank.sv
module ctxsch_sem_bank
    import ctxsch_pkg::*;
#(
    parameter int NUM_CTX = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  ctx_id_t            writer,
    input  ctx_id_t            target,
    input  logic               wdata,
    input  ctx_id_t            active,
    output logic [NUM_CTX:0]   flags,
    output logic               active_wait
);

    logic accept;

    assign accept   = we && flag_write_ok(writer, target, NUM_CTX);
    assign flags[0] = 1'b0;

    for (genvar g = 1; g <= NUM_CTX; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
            end else if (accept && (target == ctx_id_t'(g))) begin
                flags[g] <= wdata;
            end
        end
    end

    assign active_wait = flags[active];

endmodule

// File: rtl/ctxsch_slice_timer.sv
module ctxsch_slice_timer
    import ctxsch_pkg::*;
#(
    parameter int BUDGET = 75,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_end,
    input  logic             yield_req,
    input  logic             halted,
    output logic             switch_now,
    output sw_cause_t        cause,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BUDGET - 1);

    always_comb begin
        cause = SW_NONE;
        if (blk_end) begin
            if (halted) begin
                cause = SW_HALT;
            end else if (yield_req) begin
                cause = SW_YIELD;
            end else if (count == LIMIT) begin
                cause = SW_BUDGET;
            end
        end
    end

    assign switch_now = (cause != SW_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (switch_now) begin
            count <= '0;
        end else if (blk_end) begin
            count <= count + 1'b1;
        end else if (yield_req) begin
            count <= LIMIT;
        end
    end

endmodule

// File: rtl/ctx_slot_sched.sv
module ctx_slot_sched
    import ctxsch_pkg::*;
#(
    parameter int NUM_CTX   = 7,
    parameter int SEQ_DEPTH = 256,
    parameter int BUDGET    = 75,
    parameter int BANK_W    = 3,
    localparam int PTR_W    = $clog2(SEQ_DEPTH),
    localparam int CNT_W    = $clog2(BUDGET + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_end,
    input  logic              yield_req,
    input  logic              sem_we,
    input  logic [CTX_W-1:0]  sem_target,
    input  logic              sem_wait,
    input  logic              seq_we,
    input  logic [PTR_W-1:0]  seq_addr,
    input  logic [CTX_W-1:0]  seq_ctx,
    input  logic              seq_last_we,
    input  logic [PTR_W-1:0]  seq_last,
    output logic [CTX_W-1:0]  ctx_id,
    output logic [BANK_W-1:0] bank_sel,
    output logic              halted
);

    localparam ctx_id_t          RESET_CTX  = default_entry(0, NUM_CTX);
    localparam logic [PTR_W-1:0] RESET_LAST = PTR_W'(NUM_CTX - 1);

    ctx_id_t          ctx_q;
    logic [BANK_W-1:0] bank_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] last_q;
    logic [PTR_W-1:0] ptr_next;
    ctx_id_t          next_entry;
    logic             switch_now;
    sw_cause_t        sw_cause;
    logic [CNT_W-1:0] slice_cnt;
    logic [NUM_CTX:0] sem_flags;
    logic             active_wait;

    assign ptr_next = (ptr_q >= last_q) ? '0 : ptr_q + 1'b1;

    ctxsch_seq_table #(
        .DEPTH   (SEQ_DEPTH),
        .NUM_CTX (NUM_CTX),
        .PTR_W   (PTR_W)
    ) table_i (
        .clk   (clk),
        .rst   (rst),
        .we    (seq_we),
        .waddr (seq_addr),
        .wdata (seq_ctx),
        .raddr (ptr_next),
        .rdata (next_entry)
    );

    ctxsch_sem_bank #(
        .NUM_CTX (NUM_CTX)
    ) sem_i (
        .clk         (clk),
        .rst         (rst),
        .we          (sem_we),
        .writer      (ctx_q),
        .target      (sem_target),
        .wdata       (sem_wait),
        .active      (ctx_q),
        .flags       (sem_flags),
        .active_wait (active_wait)
    );

    ctxsch_slice_timer #(
        .BUDGET (BUDGET),
        .CNT_W  (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .blk_end    (blk_end),
        .yield_req  (yield_req),
        .halted     (active_wait),
        .switch_now (switch_now),
        .cause      (sw_cause),
        .count      (slice_cnt)
    );

    // Pointer, context and bank move only on a switch
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            ctx_q  <= RESET_CTX;
            bank_q <= BANK_W'(RESET_CTX);
        end else if (switch_now) begin
            ptr_q <= ptr_next;
            if (next_entry != '0) begin
                ctx_q  <= next_entry;
                bank_q <= BANK_W'(next_entry);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= RESET_LAST;
        end else if (seq_last_we) begin
            last_q <= seq_last;
        end
    end

    assign ctx_id   = ctx_q;
    assign bank_sel = bank_q;
    assign halted   = active_wait;

endmodule

// File: rtl/ctx_slot_sched_chk.sv
module ctx_slot_sched_chk #(
    parameter int NUM_CTX = 7,
    parameter int BUDGET  = 75,
    parameter int CNT_W   = 7,
    parameter int BANK_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              blk_end,
    input logic              yield_req,
    input logic              sem_we,
    input logic [2:0]        sem_target,
    input logic [2:0]        ctx_id,
    input logic [BANK_W-1:0] bank_sel,
    input logic              halted,
    input logic [CNT_W-1:0]  slice_cnt,
    input logic [NUM_CTX:0]  sem_flags
);

    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !blk_end |=> $stable(ctx_id)); // R2

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !blk_end |=> $stable(bank_sel)); // R5

    AST_SLICE_END: assert property (@(posedge clk) disable iff (rst)
        (blk_end && (int'(slice_cnt) == BUDGET - 1)) |=> (slice_cnt == '0)); // R2

    AST_YIELD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (yield_req && !blk_end) |=> (int'(slice_cnt) == BUDGET - 1)); // R6

    AST_HALT_GIVEUP: assert property (@(posedge clk) disable iff (rst)
        (blk_end && halted) |=> (slice_cnt == '0)); // R7

    AST_SEM_DENY: assert property (@(posedge clk) disable iff (rst)
        (sem_we && (ctx_id != 3'd1) && (sem_target != ctx_id)) |=> $stable(sem_flags)); // R8

    always @(posedge clk) begin
        if (!rst) begin
            AST_CTX_RANGE: assert ((ctx_id != 3'd0) && (int'(ctx_id) <= NUM_CTX)); // R1
            AST_CNT_BOUND: assert (int'(slice_cnt) < BUDGET); // R2
        end
    end

endmodule

bind ctx_slot_sched ctx_slot_sched_chk #(
    .NUM_CTX (NUM_CTX),
    .BUDGET  (BUDGET),
    .CNT_W   (CNT_W),
    .BANK_W  (BANK_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .blk_end    (blk_end),
    .yield_req  (yield_req),
    .sem_we     (sem_we),
    .sem_target (sem_target),
    .ctx_id     (ctx_id),
    .bank_sel   (bank_sel),
    .halted     (halted),
    .slice_cnt  (slice_cnt),
    .sem_flags  (sem_flags)
);

// File: tb/ctx_slot_sched_tb_top.sv
module ctx_slot_sched_tb_top;

    localparam int BUDGET = 75;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blk_end = 1'b0;
    logic       yield_req = 1'b0;
    logic       sem_we = 1'b0;
    logic [2:0] sem_target = '0;
    logic       sem_wait = 1'b0;
    logic       seq_we = 1'b0;
    logic [7:0] seq_addr = '0;
    logic [2:0] seq_ctx = '0;
    logic       seq_last_we = 1'b0;
    logic [7:0] seq_last = '0;
    logic [2:0] ctx_id;
    logic [2:0] bank_sel;
    logic       halted;

    ctx_slot_sched dut_i (
        .clk         (clk),
        .rst         (rst),
        .blk_end     (blk_end),
        .yield_req   (yield_req),
        .sem_we      (sem_we),
        .sem_target  (sem_target),
        .sem_wait    (sem_wait),
        .seq_we      (seq_we),
        .seq_addr    (seq_addr),
        .seq_ctx     (seq_ctx),
        .seq_last_we (seq_last_we),
        .seq_last    (seq_last),
        .ctx_id      (ctx_id),
        .bank_sel    (bank_sel),
        .halted      (halted)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int    m_tab [256];
    int    m_last, m_ptr, m_ctx, m_bank, m_cnt;
    bit    m_wait [8];
    bit    m_valid = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) m_tab[i] = (i % 7) + 1;
            for (int i = 0; i < 8; i++) m_wait[i] = 0;
            m_last = 6; m_ptr = 0; m_ctx = 1; m_bank = 1; m_cnt = 0;
            m_valid = 1;
        end else begin
            bit hold_wait;
            int np;
            hold_wait = m_wait[m_ctx];
            if (blk_end) begin
                if (m_cnt + 1 >= BUDGET || yield_req || hold_wait) begin
                    np = (m_ptr >= m_last) ? 0 : m_ptr + 1;
                    m_ptr = np;
                    if (m_tab[np] != 0) begin
                        m_ctx = m_tab[np];
                        m_bank = m_tab[np];
                    end
                    m_cnt = 0;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else if (yield_req) begin
                m_cnt = BUDGET - 1;
            end
            if (sem_we && sem_target != 0 &&
                (int'(sem_target) == m_ctx || m_ctx == 1)) begin
                m_wait[sem_target] = sem_wait;
            end
            if (seq_we) m_tab[seq_addr] = seq_ctx;
            if (seq_last_we) m_last = seq_last;
        end
    end

    task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !rst && !done) begin
            expect_val({cur_req, " ctx_id"}, 32'(ctx_id), 32'(m_ctx));
            expect_val({cur_req, " bank_sel"}, 32'(bank_sel), 32'(m_bank));
            expect_val({cur_req, " halted"}, 32'(halted), 32'(m_wait[m_ctx]));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic step(bit be, bit y);
        blk_end = be; yield_req = y;
        @(negedge clk);
        blk_end = 0; yield_req = 0;
    endtask

    task automatic blocks(int n);
        for (int k = 0; k < n; k++) begin
            step(1, 0);
            step(0, 0);
        end
    endtask

    task automatic sem_wr(int t, bit d);
        sem_we = 1; sem_target = 3'(t); sem_wait = d;
        @(negedge clk);
        sem_we = 0;
    endtask

    task automatic tab_wr(int a, int d);
        seq_we = 1; seq_addr = 8'(a); seq_ctx = 3'(d);
        @(negedge clk);
        seq_we = 0;
    endtask

    task automatic last_wr(int l);
        seq_last_we = 1; seq_last = 8'(l);
        @(negedge clk);
        seq_last_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        cur_req = "R1";
        expect_val("R1 reset ctx", 32'(ctx_id), 1);
        expect_val("R1 reset bank", 32'(bank_sel), 1);
        expect_val("R1 reset halted", 32'(halted), 0);

        cur_req = "R2";
        blocks(BUDGET - 1);
        expect_val("R2 before budget", 32'(ctx_id), 1);
        blocks(1);
        expect_val("R2 after budget", 32'(ctx_id), 2);

        cur_req = "R3";
        blocks(BUDGET * 5);
        expect_val("R3 last entry", 32'(ctx_id), 7);
        blocks(BUDGET);
        expect_val("R3 wrap to entry 0", 32'(ctx_id), 1);

        cur_req = "R9";
        last_wr(2);
        tab_wr(1, 4);
        tab_wr(2, 0);
        blocks(BUDGET);
        expect_val("R9 written entry", 32'(ctx_id), 4);

        cur_req = "R4";
        blocks(BUDGET);
        expect_val("R4 null keeps ctx", 32'(ctx_id), 4);
        expect_val("R4 null keeps bank", 32'(bank_sel), 4);
        blocks(BUDGET - 1);
        expect_val("R4 fresh budget", 32'(ctx_id), 4);
        blocks(1);
        expect_val("R4 after extended slice", 32'(ctx_id), 1);

        cur_req = "R6";
        blocks(10);
        step(0, 1);
        blocks(1);
        expect_val("R6 yield then block", 32'(ctx_id), 4);
        tab_wr(2, 5);
        blocks(3);
        step(1, 1);
        step(0, 0);
        expect_val("R6 same-cycle yield", 32'(ctx_id), 5);
        expect_val("R5 bank follows", 32'(bank_sel), 5);
        step(0, 1);
        blocks(1);
        expect_val("R6 yield wraps", 32'(ctx_id), 1);

        cur_req = "R8";
        last_wr(3);
        tab_wr(1, 3);
        tab_wr(2, 5);
        tab_wr(3, 2);
        sem_wr(3, 1);
        sem_wr(0, 1);
        expect_val("R8 supervisor own flag clear", 32'(halted), 0);
        step(0, 1);
        blocks(1);
        cur_req = "R7";
        expect_val("R7 ctx3 selected", 32'(ctx_id), 3);
        expect_val("R7 ctx3 halted", 32'(halted), 1);
        blocks(1);
        expect_val("R7 halted gives up", 32'(ctx_id), 5);
        cur_req = "R8";
        sem_wr(3, 0);
        sem_wr(1, 1);
        expect_val("R8 foreign write ignored", 32'(halted), 0);
        sem_wr(5, 1);
        expect_val("R8 own write accepted", 32'(halted), 1);
        blocks(1);
        expect_val("R8 to ctx2", 32'(ctx_id), 2);
        expect_val("R8 ctx1 flag untouched", 32'(halted), 0);
        step(0, 1);
        blocks(1);
        expect_val("R8 back to ctx1", 32'(ctx_id), 1);
        expect_val("R8 ctx1 not waiting", 32'(halted), 0);
        sem_wr(5, 0);
        step(0, 1);
        blocks(1);
        expect_val("R8 ctx3 still waiting", 32'(halted), 1);
        blocks(1);
        cur_req = "R7";
        expect_val("R7 ctx5 signalled", 32'(ctx_id), 5);
        expect_val("R7 ctx5 runs", 32'(halted), 0);

        cur_req = "R5";
        for (int it = 0; it < 8000; it++) begin
            if ($urandom_range(99) < 5) sem_wr($urandom_range(7), 1'($urandom_range(1)));
            if ($urandom_range(99) < 2) tab_wr($urandom_range(15), $urandom_range(7));
            if ($urandom_range(199) < 1) last_wr($urandom_range(15));
            step(1'($urandom_range(1)), ($urandom_range(99) < 4));
        end

        finish_run();
    end

endmodule